// File: doc/BRIEF.md
# Weight Readout Address Generator

This block produces the sequence of flat element indices needed to stream a convolution weight tensor out of its on-chip memory. The tensor holds K output channels, each with C input channels and an H×W kernel window. It is stored with the output-channel dimension contiguous, so each memory word carries weights for several output channels at once. The index is the sum of three counters, and the steps and limits are set up so that no multiplier is needed. The outer tiling counter picks the group of output channels for one computing context. The middle in-tile counter walks the window and input-channel positions in memory order, one K-stride at a time. The inner auxiliary counter repeats within one in-tile position, for when the weights of one batch straddle two memory words.

Software loads the K size, the full tensor span (K·W·H·C), the tile step, and the auxiliary limit and step, then pulses start. The block then offers one index per accepted handshake. Each index is split into a word address and an element offset within the word, for the memory port and the downstream lane selector. When the last index of the last tile has been taken, a one-cycle done pulse follows. All configured limits and steps must be nonzero.

Top module: `wgt_idx_gen`

## Requirements
- R1: After reset, out_valid and done are 0, and they stay 0 until start is pulsed, whatever out_ready does.
- R2: While a run is active, out_valid is 1 and out_idx equals aux + intile + tile. The counters are nested with tile outermost, then intile, then aux innermost.
- R3: The tile count starts at 0, advances by cfg_tile_step each time the in-tile count wraps, and wraps when the next value would reach or exceed cfg_k.
- R4: The in-tile count starts at 0, advances by cfg_k each time the aux count wraps, and wraps when the next value would reach or exceed cfg_span.
- R5: The aux count starts at 0, advances by cfg_aux_step on each accepted index, and wraps when the next value would reach or exceed cfg_aux_lim. With cfg_aux_lim equal to cfg_aux_step, there is exactly one aux pass per in-tile position.
- R6: out_addr equals out_idx shifted right by log2(ELEM_PER_WORD), and out_ofs equals out_idx masked with ELEM_PER_WORD−1. The default is 8 elements per word: a 3-bit offset in the low bits.
- R7: The counters move only on a cycle with out_valid and out_ready both high and start low. While the consumer stalls, out_idx holds its value.
- R8: One cycle after the final index is accepted, done is 1 for exactly one cycle and out_valid is 0.
- R9: A start pulse latches the configuration inputs and clears all counters, including in the middle of a run. The first index offered afterwards is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch configuration and restart the walk from zero |
| cfg_k | input | IDX_W | Output-channel count; limit of the tile counter and step of the in-tile counter |
| cfg_span | input | IDX_W | K·W·H·C; limit of the in-tile counter |
| cfg_tile_step | input | IDX_W | Output channels advanced per tile |
| cfg_aux_lim | input | IDX_W | Limit of the auxiliary counter |
| cfg_aux_step | input | IDX_W | Step of the auxiliary counter |
| out_valid | output | 1 | An index is offered |
| out_ready | input | 1 | The consumer takes the offered index |
| out_idx | output | IDX_W | Global element index |
| out_addr | output | IDX_W−log2(ELEM_PER_WORD) | Memory word address |
| out_ofs | output | log2(ELEM_PER_WORD) | Element position within the word |
| done | output | 1 | One-cycle pulse after the last index is accepted |

## Verification
The bench sweeps many small tensor shapes, tile steps and auxiliary settings. This includes tile steps that do not divide K, which leave a partial final tile, and an auxiliary limit equal to its step. A design that compared with "equal" instead of "reach or exceed" would miss the wrap on a partial tile and run past K. A design that mishandled the single-pass auxiliary case would offer each in-tile position twice or skip it. The consumer stalls on an irregular pattern. This exposes a counter that advances without a handshake or an index that changes while stalled. It also exposes a done pulse that comes a cycle early, lasts two cycles, or arrives while valid is still high. A restart in the middle of a run checks that stale counter values are not carried into the new configuration.

// File: rtl/wgt_idx_pkg.sv
package wgt_idx_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_t;
endpackage

// File: rtl/wgt_step_counter.sv
module wgt_step_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt_sum;

  function automatic logic [W:0] add_step(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign nxt_sum = add_step(cnt_q, step);
  assign wrap    = (nxt_sum >= {1'b0, lim});
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (adv)     cnt_q <= wrap ? '0 : nxt_sum[W-1:0];
  end

  AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (cnt_q < $past(lim))); // R5
endmodule

// File: rtl/wgt_idx_split.sv
module wgt_idx_split #(
  parameter int IDX_W         = 16,
  parameter int ELEM_PER_WORD = 8,
  localparam int OFS_W  = $clog2(ELEM_PER_WORD),
  localparam int ADDR_W = IDX_W - OFS_W
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [OFS_W-1:0]  ofs
);
  function automatic logic [ADDR_W-1:0] word_of(input logic [IDX_W-1:0] v);
    return v[IDX_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] lane_of(input logic [IDX_W-1:0] v);
    return v[OFS_W-1:0];
  endfunction

  assign addr = word_of(idx);
  assign ofs  = lane_of(idx);
endmodule

// File: rtl/wgt_idx_gen.sv
module wgt_idx_gen
  import wgt_idx_pkg::*;
#(
  parameter int IDX_W         = 16,
  parameter int ELEM_PER_WORD = 8,
  localparam int OFS_W  = $clog2(ELEM_PER_WORD),
  localparam int ADDR_W = IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cfg_k,
  input  logic [IDX_W-1:0]  cfg_span,
  input  logic [IDX_W-1:0]  cfg_tile_step,
  input  logic [IDX_W-1:0]  cfg_aux_lim,
  input  logic [IDX_W-1:0]  cfg_aux_step,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OFS_W-1:0]  out_ofs,
  output logic              done
);
  run_state_t       state_q;
  logic [IDX_W-1:0] k_q, span_q, tstep_q, alim_q, astep_q;
  logic             done_q;

  // named internal events
  logic fire, adv_aux, adv_mid, adv_tile, last_fire;
  logic aux_wrap, mid_wrap, tile_wrap;
  logic [IDX_W-1:0] aux_cnt, mid_cnt, tile_cnt;

  assign out_valid = (state_q == RUN_BUSY);
  assign fire      = out_valid && out_ready && !start;
  assign adv_aux   = fire;
  assign adv_mid   = adv_aux && aux_wrap;
  assign adv_tile  = adv_mid && mid_wrap;
  assign last_fire = adv_tile && tile_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      k_q     <= '0;
      span_q  <= '0;
      tstep_q <= '0;
      alim_q  <= '0;
      astep_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_fire;
      if (start) begin
        state_q <= RUN_BUSY;
        k_q     <= cfg_k;
        span_q  <= cfg_span;
        tstep_q <= cfg_tile_step;
        alim_q  <= cfg_aux_lim;
        astep_q <= cfg_aux_step;
      end else if (last_fire) begin
        state_q <= RUN_IDLE;
      end
    end
  end

  wgt_step_counter #(.W(IDX_W)) i_aux (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv_aux),
    .step(astep_q), .lim(alim_q), .cnt(aux_cnt), .wrap(aux_wrap));

  wgt_step_counter #(.W(IDX_W)) i_mid (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv_mid),
    .step(k_q), .lim(span_q), .cnt(mid_cnt), .wrap(mid_wrap));

  wgt_step_counter #(.W(IDX_W)) i_tile (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv_tile),
    .step(tstep_q), .lim(k_q), .cnt(tile_cnt), .wrap(tile_wrap));

  assign out_idx = aux_cnt + mid_cnt + tile_cnt;
  assign done    = done_q;

  wgt_idx_split #(.IDX_W(IDX_W), .ELEM_PER_WORD(ELEM_PER_WORD)) i_split (
    .idx(out_idx), .addr(out_addr), .ofs(out_ofs));

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_idx))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && !out_valid)); // R8
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_valid && out_idx == '0)); // R9
  AST_TILE_BELOW_K: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tile_cnt < k_q)); // R3
endmodule

// File: tb/test_wgt_idx_gen.sv
module test_wgt_idx_gen;
  localparam int IDX_W = 16;
  localparam int EPW   = 8;
  localparam int OFS_W = 3;
  localparam int ADDR_W = IDX_W - OFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  cfg_k = '0, cfg_span = '0, cfg_tile_step = '0;
  logic [IDX_W-1:0]  cfg_aux_lim = '0, cfg_aux_step = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [IDX_W-1:0]  out_idx;
  logic [ADDR_W-1:0] out_addr;
  logic [OFS_W-1:0]  out_ofs;
  logic              done;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  wgt_idx_gen #(.IDX_W(IDX_W), .ELEM_PER_WORD(EPW)) i_wgt_idx_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_k(cfg_k), .cfg_span(cfg_span), .cfg_tile_step(cfg_tile_step),
    .cfg_aux_lim(cfg_aux_lim), .cfg_aux_step(cfg_aux_step),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_addr(out_addr), .out_ofs(out_ofs), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit next_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] | lfsr[3];
  endfunction

  // abort_after >= 0: stop after that many accepted indices (no done expected)
  task automatic run_cfg(input int k, input int whc, input int tile,
                         input int al, input int as_, input int abort_after);
    int span, e_til, e_w, e_a, acc, exp_idx, prev_idx, guard;
    bit first, stalled, last, finished, rdy;
    span = k * whc;
    @(negedge clk);
    cfg_k = k[IDX_W-1:0]; cfg_span = span[IDX_W-1:0];
    cfg_tile_step = tile[IDX_W-1:0];
    cfg_aux_lim = al[IDX_W-1:0]; cfg_aux_step = as_[IDX_W-1:0];
    start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    e_til = 0; e_w = 0; e_a = 0; acc = 0; prev_idx = 0;
    first = 1; stalled = 0; last = 0; finished = 0; guard = 0;
    while (!finished) begin
      exp_idx = e_a + e_w + e_til;
      chk(out_valid == 1'b1, "R2 valid during run", int'(out_valid), 1);
      if (first) chk(out_idx == 0, "R9 first index after start", int'(out_idx), 0);
      first = 0;
      if (stalled) chk(out_idx == prev_idx[IDX_W-1:0], "R7 hold on stall", int'(out_idx), prev_idx);
      // index model: R2 sum, R3 tile, R4 in-tile, R5 aux stepping
      chk(int'(out_idx) == exp_idx, "R2 R3 R4 R5 index", int'(out_idx), exp_idx);
      chk(int'(out_addr) == (exp_idx >> 3), "R6 word address", int'(out_addr), exp_idx >> 3);
      chk(int'(out_ofs) == (exp_idx & 7), "R6 element offset", int'(out_ofs), exp_idx & 7);
      prev_idx = int'(out_idx);
      rdy = next_ready();
      out_ready = rdy;
      stalled = !rdy;
      if (rdy) begin
        acc++;
        e_a += as_;
        if (e_a >= al) begin
          e_a = 0; e_w += k;
          if (e_w >= span) begin
            e_w = 0; e_til += tile;
            if (e_til >= k) begin e_til = 0; last = 1; end
          end
        end
      end
      @(negedge clk);
      if (abort_after >= 0 && acc == abort_after) begin
        out_ready = 1'b0;
        finished = 1;
      end else if (last) begin
        out_ready = 1'b0;
        chk(done == 1'b1, "R8 done after last", int'(done), 1);
        chk(out_valid == 1'b0, "R8 valid low at done", int'(out_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
        finished = 1;
      end else begin
        chk(done == 1'b0, "R8 no early done", int'(done), 0);
      end
      guard++;
      if (guard > 5000) begin
        chk(1'b0, "R8 run did not finish", guard, 0);
        finished = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle with ready high", int'(out_valid), 0);
    chk(done == 1'b0, "R1 no done while idle", int'(done), 0);
    out_ready = 1'b0;

    // R5 single aux pass: limit equals step
    run_cfg(4, 3, 2, 1, 1, -1);
    run_cfg(6, 3, 3, 4, 2, -1);
    run_cfg(5, 2, 5, 3, 1, -1);
    run_cfg(8, 1, 1, 2, 2, -1);
    run_cfg(7, 2, 3, 5, 2, -1);   // partial last tile (R3)
    // R9 restart mid-run, then a different configuration
    run_cfg(6, 3, 2, 4, 2, 5);
    run_cfg(4, 2, 1, 2, 1, -1);

    for (int k = 1; k <= 4; k++)
      for (int w = 1; w <= 3; w++)
        for (int t = 1; t <= k; t++)
          for (int s = 1; s <= 2; s++)
            for (int l = s; l <= 3; l++)
              run_cfg(k, w, t, l, s, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule